// File: doc/BRIEF.md
# Byte ALU with Shared Operand Inversion

This block is the combinational execution stage of a small byte-wide processor. It accepts a first operand `sri_i` and a second operand `snd_i`, together with three side sources: a byte read from an input port, the incremented program counter and the output of a separate left shifter. A 4-bit operation code is decoded into a set of enable lines. Those lines steer the operands through one shared stage that can block, pass or invert the second operand, through a bitwise logic network, and through a ripple-carry adder.

A last selection level combines the gated sources into one byte. Because the decoder never enables two sources at once, the selection is a plain OR of gated values rather than a priority chain. The block also reports a zero flag for the result and a carry-out for additions and subtractions. Registers, the shifter itself and the program counter are outside the block. Every output settles within the same cycle as its inputs.

Top module: `alu8_datapath`

## Requirements
- R1: Code 0 (OR) gives result = sri | snd.
- R2: Code 1 (XOR) gives result = sri ^ snd.
- R3: Code 2 (AND) gives result = sri & snd.
- R4: Code 3 (AND-NOT) gives result = sri & ~snd.
- R5: Code 5 (ADD) gives result = low 8 bits of sri + snd, with carry_o equal to bit 8 of that sum.
- R6: Code 4 (SUB) gives result = low 8 bits of sri + ~snd + 1, with carry_o equal to bit 8 of that sum, so carry_o = 1 means no borrow.
- R7: Code 6 (PASS) gives result = sri, and snd has no effect on it.
- R8: Code 7 (IN) gives result = in_port_i.
- R9: Code 8 (CLEAR) and the unused codes 11 to 15 give result = 0.
- R10: Code 9 (NPC) gives result = npc_i.
- R11: Code 10 (SHL) gives result = shl_i.
- R12: zero_o is 1 exactly when all 8 result bits are 0, for every code.
- R13: carry_o is 0 for every code except ADD and SUB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| sri_i | input | 8 | First operand |
| snd_i | input | 8 | Second operand |
| in_port_i | input | 8 | Byte from the input port |
| npc_i | input | 8 | Incremented program counter |
| shl_i | input | 8 | Result from the left shifter |
| result_o | output | 8 | Selected result byte |
| zero_o | output | 1 | High when the result is all zeros |
| carry_o | output | 1 | Adder carry-out, low for non-arithmetic codes |

## Verification
The hardest case to reach is the carry chain running its full length: a carry born at bit 0 rippling to bit 8, and a subtraction of equal operands. In that subtraction the inverted operand plus the forced carry-in wraps exactly to zero, so both the carry and the zero flag rise together. The stimulus reaches these by pairing every code with corner operand sets built from 0x00, 0xFF and 0x80, including 0xFF + 0x01, 0x80 - 0x80 and 0x00 - 0x01. Random operands then cover the rest. For the PASS and unused codes, the side sources are driven with non-zero values so that any leakage would show in the result.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_OR   = 4'd0,
    OP_XOR  = 4'd1,
    OP_AND  = 4'd2,
    OP_ANDN = 4'd3,
    OP_SUB  = 4'd4,
    OP_ADD  = 4'd5,
    OP_PASS = 4'd6,
    OP_IN   = 4'd7,
    OP_CLR  = 4'd8,
    OP_NPC  = 4'd9,
    OP_SHL  = 4'd10
  } alu_op_e;

  // Decoded steering lines
  typedef struct packed {
    logic inv_b;     // invert second operand (also adder carry-in)
    logic keep_b;    // let second operand through unchanged
    logic and_sel;   // logic network: AND when mix_sel low
    logic xor_sel;   // logic network: XOR rather than OR when mix_sel high
    logic mix_sel;   // logic network: OR/XOR family
    logic logic_en;  // logic result reaches output
    logic sum_en;    // adder result reaches output
    logic port_en;   // input-port byte reaches output
    logic gate_en;   // final gate for the logic path
    logic npc_en;    // next PC reaches output
    logic shl_en;    // shifter result reaches output
  } alu_ctl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_ctl_t        ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (alu_op_e'(op_i))
      OP_OR: begin
        ctl_o.keep_b   = 1'b1;
        ctl_o.mix_sel  = 1'b1;
        ctl_o.logic_en = 1'b1;
        ctl_o.gate_en  = 1'b1;
      end
      OP_XOR: begin
        ctl_o.keep_b   = 1'b1;
        ctl_o.xor_sel  = 1'b1;
        ctl_o.mix_sel  = 1'b1;
        ctl_o.logic_en = 1'b1;
        ctl_o.gate_en  = 1'b1;
      end
      OP_AND: begin
        ctl_o.keep_b   = 1'b1;
        ctl_o.and_sel  = 1'b1;
        ctl_o.xor_sel  = 1'b1;
        ctl_o.logic_en = 1'b1;
        ctl_o.gate_en  = 1'b1;
      end
      OP_ANDN: begin
        ctl_o.inv_b    = 1'b1;
        ctl_o.and_sel  = 1'b1;
        ctl_o.xor_sel  = 1'b1;
        ctl_o.logic_en = 1'b1;
        ctl_o.gate_en  = 1'b1;
      end
      OP_SUB: begin
        ctl_o.inv_b    = 1'b1;
        ctl_o.xor_sel  = 1'b1;
        ctl_o.mix_sel  = 1'b1;
        ctl_o.sum_en   = 1'b1;
      end
      OP_ADD: begin
        ctl_o.keep_b   = 1'b1;
        ctl_o.xor_sel  = 1'b1;
        ctl_o.mix_sel  = 1'b1;
        ctl_o.sum_en   = 1'b1;
      end
      OP_PASS: begin
        ctl_o.mix_sel  = 1'b1;
        ctl_o.logic_en = 1'b1;
        ctl_o.gate_en  = 1'b1;
      end
      OP_IN:   ctl_o.port_en = 1'b1;
      OP_NPC:  ctl_o.npc_en  = 1'b1;
      OP_SHL:  ctl_o.shl_en  = 1'b1;
      default: ctl_o = '0;  // clear and unused codes
    endcase
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_b_i,
  input  logic             keep_b_i,
  input  logic             and_sel_i,
  input  logic             xor_sel_i,
  input  logic             mix_sel_i,
  output logic [WIDTH-1:0] b_mod_o,
  output logic [WIDTH-1:0] y_o
);

  // Per-bit slice: operand conditioning feeds the shared logic network
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic b_bit;
    logic t_and;
    logic t_xor;
    logic t_or;

    always_comb begin
      if (keep_b_i)     b_bit = b_i[i];
      else if (inv_b_i) b_bit = ~b_i[i];
      else              b_bit = 1'b0;

      t_and = a_i[i] & b_bit;
      t_xor = a_i[i] ^ b_bit;
      t_or  = a_i[i] | b_bit;

      if (mix_sel_i)      y_o[i] = xor_sel_i ? t_xor : t_or;
      else if (and_sel_i) y_o[i] = t_and;
      else                y_o[i] = 1'b0;
    end

    assign b_mod_o[i] = b_bit;
  end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic prop;
    assign prop         = a_i[i] ^ b_i[i];
    assign sum_o[i]     = prop ^ chain[i];
    assign chain[i+1]   = (a_i[i] & b_i[i]) | (prop & chain[i]);
  end

  assign cout_o = chain[WIDTH];

endmodule

// File: rtl/alu8_resmux.sv
module alu8_resmux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] logic_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] npc_i,
  input  logic [WIDTH-1:0] shl_i,
  input  logic             logic_en_i,
  input  logic             gate_en_i,
  input  logic             sum_en_i,
  input  logic             port_en_i,
  input  logic             npc_en_i,
  input  logic             shl_en_i,
  output logic [WIDTH-1:0] y_o,
  output logic             zero_o
);

  logic [WIDTH-1:0] g_logic, g_sum, g_port, g_npc, g_shl;

  always_comb begin
    g_logic = (logic_en_i && gate_en_i) ? logic_i : '0;
    g_sum   = sum_en_i  ? sum_i  : '0;
    g_port  = port_en_i ? port_i : '0;
    g_npc   = npc_en_i  ? npc_i  : '0;
    g_shl   = shl_en_i  ? shl_i  : '0;
    // Decoder guarantees one source at most, so OR is a clean merge
    y_o     = g_logic | g_sum | g_port | g_npc | g_shl;
    zero_o  = ~(|y_o);
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] sri_i,
  input  logic [WIDTH-1:0] snd_i,
  input  logic [WIDTH-1:0] in_port_i,
  input  logic [WIDTH-1:0] npc_i,
  input  logic [WIDTH-1:0] shl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             carry_o
);

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] b_mod;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] sum_y;
  logic             add_cout;

  alu8_decode u_decode (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i       (sri_i),
    .b_i       (snd_i),
    .inv_b_i   (ctl.inv_b),
    .keep_b_i  (ctl.keep_b),
    .and_sel_i (ctl.and_sel),
    .xor_sel_i (ctl.xor_sel),
    .mix_sel_i (ctl.mix_sel),
    .b_mod_o   (b_mod),
    .y_o       (logic_y)
  );

  // Inversion line doubles as carry-in: SUB = a + ~b + 1
  alu8_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i    (sri_i),
    .b_i    (b_mod),
    .cin_i  (ctl.inv_b),
    .sum_o  (sum_y),
    .cout_o (add_cout)
  );

  alu8_resmux #(.WIDTH(WIDTH)) u_resmux (
    .logic_i    (logic_y),
    .sum_i      (sum_y),
    .port_i     (in_port_i),
    .npc_i      (npc_i),
    .shl_i      (shl_i),
    .logic_en_i (ctl.logic_en),
    .gate_en_i  (ctl.gate_en),
    .sum_en_i   (ctl.sum_en),
    .port_en_i  (ctl.port_en),
    .npc_en_i   (ctl.npc_en),
    .shl_en_i   (ctl.shl_en),
    .y_o        (result_o),
    .zero_o     (zero_o)
  );

  assign carry_o = add_cout & ctl.sum_en;

endmodule

// File: rtl/alu8_datapath_chk.sv
module alu8_datapath_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] sri_i,
  input logic [WIDTH-1:0] in_port_i,
  input logic [WIDTH-1:0] npc_i,
  input logic [WIDTH-1:0] shl_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             carry_o
);

  always_comb begin
    // R12: flag matches the result byte
    a_r12_zero_flag: assert (zero_o == (result_o == '0));
    // R13: no carry outside ADD/SUB
    if (op_i != 4'd4 && op_i != 4'd5)
      a_r13_no_carry: assert (!carry_o);
    // R9: clear and unused codes drive zero
    if (op_i == 4'd8 || op_i > 4'd10)
      a_r9_clear: assert (result_o == '0 && zero_o);
    // R8: input port selection
    if (op_i == 4'd7)
      a_r8_port: assert (result_o == in_port_i);
    // R10: next PC selection
    if (op_i == 4'd9)
      a_r10_npc: assert (result_o == npc_i);
    // R11: shifter selection
    if (op_i == 4'd10)
      a_r11_shl: assert (result_o == shl_i);
    // R7: pass-through of the first operand
    if (op_i == 4'd6)
      a_r7_pass: assert (result_o == sri_i);
  end

endmodule

bind alu8_datapath alu8_datapath_chk #(.WIDTH(WIDTH)) u_chk (
  .op_i      (op_i),
  .sri_i     (sri_i),
  .in_port_i (in_port_i),
  .npc_i     (npc_i),
  .shl_i     (shl_i),
  .result_o  (result_o),
  .zero_o    (zero_o),
  .carry_o   (carry_o)
);

// File: tb/test_alu8_datapath.sv
module test_alu8_datapath;

  logic       clk;
  logic [3:0] op;
  logic [7:0] sri, snd, inp, npc, shl;
  logic [7:0] result;
  logic       zero, carry;

  typedef struct {
    logic [7:0] res;
    logic       z;
    logic       c;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  alu8_datapath i_alu8_datapath (
    .op_i      (op),
    .sri_i     (sri),
    .snd_i     (snd),
    .in_port_i (inp),
    .npc_i     (npc),
    .shl_i     (shl),
    .result_o  (result),
    .zero_o    (zero),
    .carry_o   (carry)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R6";
      4'd5: return "R5";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd9: return "R10";
      4'd10: return "R11";
      default: return "R9";
    endcase
  endfunction

  // Reference model written from the requirements
  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] p, input logic [7:0] n, input logic [7:0] s);
    exp_t       e;
    logic [8:0] t;
    @(negedge clk);
    op = o; sri = a; snd = b; inp = p; npc = n; shl = s;
    e.c = 1'b0;
    case (o)
      4'd0: e.res = a | b;
      4'd1: e.res = a ^ b;
      4'd2: e.res = a & b;
      4'd3: e.res = a & ~b;
      4'd4: begin t = {1'b0, a} + {1'b0, ~b} + 9'd1; e.res = t[7:0]; e.c = t[8]; end
      4'd5: begin t = {1'b0, a} + {1'b0, b};         e.res = t[7:0]; e.c = t[8]; end
      4'd6: e.res = a;
      4'd7: e.res = p;
      4'd9: e.res = n;
      4'd10: e.res = s;
      default: e.res = 8'h00;
    endcase
    e.z   = (e.res == 8'h00);  // R12
    e.tag = tag_of(o);
    exp_q.push_back(e);
  endtask

  // Monitor: compares at the rising edge, half a period after inputs move
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (result !== e.res || zero !== e.z || carry !== e.c) begin
          n_fail++;
          $display("FAIL %s (R12/R13 flags) op=%0d: got res=%02h z=%0b c=%0b, expected res=%02h z=%0b c=%0b",
                   e.tag, op, result, zero, carry, e.res, e.z, e.c);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] corner [3];
    corner[0] = 8'h00; corner[1] = 8'hFF; corner[2] = 8'h80;
    op = 4'd8; sri = '0; snd = '0; inp = '0; npc = '0; shl = '0;

    // Reset-like idle state: clear code with all-zero inputs (R9)
    drive(4'd8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);

    // Carry chain extremes (R5, R6)
    drive(4'd5, 8'hFF, 8'h01, 8'hA5, 8'h5A, 8'h3C);
    drive(4'd4, 8'h80, 8'h80, 8'hA5, 8'h5A, 8'h3C);
    drive(4'd4, 8'h00, 8'h01, 8'hA5, 8'h5A, 8'h3C);
    drive(4'd5, 8'h80, 8'h80, 8'hA5, 8'h5A, 8'h3C);

    // Every code against every corner pair, side sources non-zero
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          drive(4'(o), corner[i], corner[j], 8'hC3, 8'h81, 8'h7E);

    // Side sources at zero so R12 sees the flag rise (R8, R10, R11)
    drive(4'd7, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF);
    drive(4'd9, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF);
    drive(4'd10, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00);

    // Random operands on every code
    for (int k = 0; k < 40; k++)
      for (int o = 0; o < 16; o++)
        drive(4'(o), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule